// File: doc/BRIEF.md
# Length-Prefixed Serial Frame Receiver

This block pulls a frame from a slave over a two-wire serial link on which the receiver is the clock master. A slave raises a request line. If reception is enabled and no local transmission is running, the block starts toggling its clock output. It shifts in one data bit per clock pulse, most significant bit first, and stores each completed byte in a 32-byte buffer. A host reads that buffer through a simple address/data port.

The block does not know the frame length when it starts. It presets a remaining-byte counter to 0xFF. When the fourth byte has arrived, it replaces the counter with that byte minus three, so the trailing checksum byte is counted as part of the frame. Every received byte is added into an 8-bit running sum, and a correct frame sums to zero. A frame that runs too long is cut short and flagged as an overflow.

After any frame ends, the block issues one extra clock pulse and then raises its status flags. A guard timer starts when a new message arrives, and a local transmitter can poll it before driving the shared line.

Top module: `serial_frame_rx`

## Requirements
- R1: A rising edge on `req_i` starts reception only when the block is idle, `rx_enable` is 1 and `tx_busy` is 0. Otherwise the edge is ignored, `sclk_o` stays low and no flag changes.
- R2: Each bit holds `sclk_o` high for SETUP_CYC cycles, then low for GAP_CYC cycles. The data line is sampled on the last high cycle. The first high cycle follows the clock edge at which the start edge is seen.
- R3: Data is inverted on the wire: `sdata_i` low is a 1 bit. Bits arrive most significant bit first. The n-th byte of a frame (counting from 0) is readable at buffer address n.
- R4: The remaining-byte counter is preset to 0xFF and decremented after every byte. When it reaches 0xFB, after the byte at index 3, it is reloaded with that byte minus 3. Reception ends when the counter reaches 0, so a frame with length byte L ≥ 4 has L+1 bytes.
- R5: At a normal end, an 8-bit sum of all received bytes equal to zero clears both `cksum_err_o` and `ovf_err_o`. Any other sum sets `cksum_err_o`. In both cases `new_msg_o` is set.
- R6: If a byte is stored at address OVF_LIMIT-1 (29 bytes stored), reception ends immediately and sets `ovf_err_o`. `new_msg_o` and `cksum_err_o` are left unchanged.
- R7: Every frame end, normal or overflow, is followed by one trailing pulse of `sclk_o` high for GAP_CYC cycles. `done_o` rises on the clock edge that ends that pulse.
- R8: A one-cycle `ack_i` pulse clears `done_o`, `new_msg_o`, `cksum_err_o` and `ovf_err_o` on the next clock edge.
- R9: When a frame ends normally, `guard_busy_o` is 1 for GUARD_CYC cycles, starting with the edge that raises `done_o`, and is 0 after that.
- R10: `sclk_o` is low whenever no reception is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Allows reception to start |
| tx_busy | input | 1 | Local transmission in progress; blocks start |
| req_i | input | 1 | Slave request; a rising edge starts a frame |
| sdata_i | input | 1 | Serial data from the slave, inverted |
| sclk_o | output | 1 | Serial clock generated by this block |
| rd_addr | input | $clog2(BUF_BYTES) | Buffer read address |
| rd_data | output | 8 | Buffer byte at `rd_addr` |
| ack_i | input | 1 | Clears all status flags |
| done_o | output | 1 | A frame has ended (normally or by overflow) |
| new_msg_o | output | 1 | A frame ended normally |
| cksum_err_o | output | 1 | Last normal frame had a nonzero sum |
| ovf_err_o | output | 1 | A frame overran the buffer limit |
| guard_busy_o | output | 1 | Post-reception guard window is active |

## Verification
The bench builds the block with SETUP_CYC=3, GAP_CYC=2, GUARD_CYC=20 and the default 32-byte buffer with OVF_LIMIT=29. A five-cycle bit period keeps a 29-byte overflow frame to about 1200 cycles. Because the setup and gap phases differ in length, a swapped or off-by-one phase shows up in the cycle-by-cycle clock comparison. The short guard window makes both its start and its expiry observable between frames. The frames cover the minimum length byte of 4, a normal 7-byte and 8-byte frame, a bad checksum, an overflow, and a good frame that follows an overflow without an acknowledge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW, PH_TAIL} rx_phase_e;

  localparam logic [7:0] CNT_PRESET  = 8'hFF;
  localparam logic [7:0] RELOAD_MARK = 8'hFB;

  function automatic logic [7:0] sum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  function automatic logic [7:0] reload_from_len(input logic [7:0] len_byte);
    return len_byte - 8'd3;
  endfunction
endpackage

// File: rtl/rxf_shift.sv
module rxf_shift
  import rxf_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int GAP_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sdata_i,
  input  logic       will_end,
  output logic       sclk_o,
  output logic       active_o,
  output logic       byte_done_o,
  output logic [7:0] byte_o,
  output logic       frame_end_o
);
  localparam int TW = $clog2(SETUP_CYC + GAP_CYC + 1);
  localparam logic [TW-1:0] HI_LOAD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LO_LOAD = TW'(GAP_CYC - 1);

  rx_phase_e     phase;
  logic [TW-1:0] tmr;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          phase_end;

  assign phase_end = (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      tmr   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_HIGH;
          tmr   <= HI_LOAD;
          bitn  <= '0;
        end
        PH_HIGH: if (phase_end) begin
          shreg <= {shreg[6:0], ~sdata_i};
          phase <= PH_LOW;
          tmr   <= LO_LOAD;
        end else tmr <= tmr - 1'b1;
        PH_LOW: if (phase_end) begin
          bitn <= bitn + 1'b1;
          if (bitn == 3'd7 && will_end) begin
            phase <= PH_TAIL;
            tmr   <= LO_LOAD;
          end else begin
            phase <= PH_HIGH;
            tmr   <= HI_LOAD;
          end
        end else tmr <= tmr - 1'b1;
        PH_TAIL: if (phase_end) phase <= PH_IDLE;
                 else tmr <= tmr - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o      = (phase == PH_HIGH) || (phase == PH_TAIL);
  assign active_o    = (phase != PH_IDLE);
  assign byte_done_o = (phase == PH_LOW) && phase_end && (bitn == 3'd7);
  assign byte_o      = shreg;
  assign frame_end_o = (phase == PH_TAIL) && phase_end;
endmodule

// File: rtl/rxf_buf.sv
module rxf_buf #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
  import rxf_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int OVF_LIMIT = 29,
  parameter int GUARD_CYC = 20,
  localparam int AW = $clog2(DEPTH),
  localparam int GW = $clog2(GUARD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          byte_done,
  input  logic [7:0]    byte_in,
  input  logic          frame_end,
  input  logic          ack_i,
  output logic          will_end,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          ovf_hit,
  output logic          done_o,
  output logic          new_msg_o,
  output logic          cksum_err_o,
  output logic          ovf_err_o,
  output logic          guard_busy_o
);
  logic [7:0]    remain, remain_dec, run_sum;
  logic [AW-1:0] wptr, wptr_nxt;
  logic          ovf_pend;
  logic [GW-1:0] guard;

  assign remain_dec = remain - 8'd1;
  assign wptr_nxt   = wptr + 1'b1;
  assign ovf_hit    = (wptr_nxt == AW'(OVF_LIMIT));
  assign will_end   = (remain_dec == 8'd0) || ovf_hit;
  assign wr_en      = byte_done;
  assign wr_addr    = wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain   <= CNT_PRESET;
      run_sum  <= '0;
      wptr     <= '0;
      ovf_pend <= 1'b0;
    end else if (start) begin
      remain   <= CNT_PRESET;
      run_sum  <= '0;
      wptr     <= '0;
      ovf_pend <= 1'b0;
    end else if (byte_done) begin
      wptr    <= wptr_nxt;
      run_sum <= sum_add(run_sum, byte_in);
      if (ovf_hit) ovf_pend <= 1'b1;
      else if (remain_dec == RELOAD_MARK) remain <= reload_from_len(byte_in);
      else remain <= remain_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      new_msg_o   <= 1'b0;
      cksum_err_o <= 1'b0;
      ovf_err_o   <= 1'b0;
      guard       <= '0;
    end else begin
      if (guard != '0) guard <= guard - 1'b1;
      if (ack_i) begin
        done_o      <= 1'b0;
        new_msg_o   <= 1'b0;
        cksum_err_o <= 1'b0;
        ovf_err_o   <= 1'b0;
      end
      if (frame_end) begin
        done_o <= 1'b1;
        if (ovf_pend) ovf_err_o <= 1'b1;
        else begin
          new_msg_o <= 1'b1;
          guard     <= GW'(GUARD_CYC);
          if (run_sum == 8'd0) begin
            cksum_err_o <= 1'b0;
            ovf_err_o   <= 1'b0;
          end else cksum_err_o <= 1'b1;
        end
      end
    end
  end

  assign guard_busy_o = (guard != '0);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
  parameter int SETUP_CYC = 3,
  parameter int GAP_CYC   = 2,
  parameter int BUF_BYTES = 32,
  parameter int OVF_LIMIT = 29,
  parameter int GUARD_CYC = 20,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_enable,
  input  logic          tx_busy,
  input  logic          req_i,
  input  logic          sdata_i,
  output logic          sclk_o,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          ack_i,
  output logic          done_o,
  output logic          new_msg_o,
  output logic          cksum_err_o,
  output logic          ovf_err_o,
  output logic          guard_busy_o
);
  logic          req_q, start, rx_active, will_end;
  logic          byte_done, frame_end, wr_en, ovf_hit;
  logic [7:0]    byte_val;
  logic [AW-1:0] wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign start = req_i && !req_q && rx_enable && !tx_busy && !rx_active;

  rxf_shift #(.SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .sdata_i(sdata_i),
    .will_end(will_end), .sclk_o(sclk_o), .active_o(rx_active),
    .byte_done_o(byte_done), .byte_o(byte_val), .frame_end_o(frame_end)
  );

  rxf_frame_ctl #(.DEPTH(BUF_BYTES), .OVF_LIMIT(OVF_LIMIT), .GUARD_CYC(GUARD_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_done(byte_done),
    .byte_in(byte_val), .frame_end(frame_end), .ack_i(ack_i),
    .will_end(will_end), .wr_en(wr_en), .wr_addr(wr_addr), .ovf_hit(ovf_hit),
    .done_o(done_o), .new_msg_o(new_msg_o), .cksum_err_o(cksum_err_o),
    .ovf_err_o(ovf_err_o), .guard_busy_o(guard_busy_o)
  );

  rxf_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(byte_val),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int AW = 5,
  parameter int OVF_LIMIT = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_busy,
  input logic          rx_active,
  input logic          sclk,
  input logic          ack,
  input logic          frame_end,
  input logic          done,
  input logic          ck_err,
  input logic          new_msg,
  input logic          guard,
  input logic          byte_done,
  input logic [AW-1:0] wr_addr
);
  // R1
  inhibit_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !rx_active) |=> !rx_active);

  // R10
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |-> !sclk);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !frame_end) |=> (!done && !new_msg && !ck_err));

  // R5
  ck_err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_err) |-> $past(frame_end));

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> done);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (int'(wr_addr) < OVF_LIMIT));

  // R9
  guard_on_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(new_msg) |-> guard);
endmodule

bind serial_frame_rx rxf_checker #(.AW(AW), .OVF_LIMIT(OVF_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .rx_active(rx_active),
  .sclk(sclk_o), .ack(ack_i), .frame_end(frame_end), .done(done_o),
  .ck_err(cksum_err_o), .new_msg(new_msg_o), .guard(guard_busy_o),
  .byte_done(byte_done), .wr_addr(wr_addr)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int S = 3, G = 2, GUARD = 20, LIMIT = 29, DEPTH = 32;

  logic clk = 0, rst_n = 0, rx_enable = 1, tx_busy = 0, req = 0, ack = 0;
  logic sdata, sclk, done, new_msg, ck_err, ovf_err, guard_busy;
  logic [4:0] rd_addr = 0;
  logic [7:0] rd_data;

  int checks = 0, failures = 0;
  int falls = 0, base = 0;
  logic [7:0] frame [64];
  bit e_done = 0, e_new = 0, e_ck = 0, e_ov = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_rx #(.SETUP_CYC(S), .GAP_CYC(G), .BUF_BYTES(DEPTH),
                    .OVF_LIMIT(LIMIT), .GUARD_CYC(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .tx_busy(tx_busy),
    .req_i(req), .sdata_i(sdata), .sclk_o(sclk), .rd_addr(rd_addr),
    .rd_data(rd_data), .ack_i(ack), .done_o(done), .new_msg_o(new_msg),
    .cksum_err_o(ck_err), .ovf_err_o(ovf_err), .guard_busy_o(guard_busy)
  );

  // slave model: presents the next bit after each falling clock edge, inverted
  always @(negedge sclk) falls <= falls + 1;
  always_comb begin
    int k;
    k = falls - base;
    if (k >= 0 && k < 512) sdata = ~frame[k / 8][7 - (k % 8)];
    else sdata = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({done, new_msg, ck_err, ovf_err} == {e_done, e_new, e_ck, e_ov}, tag,
        {done, new_msg, ck_err, ovf_err}, {e_done, e_new, e_ck, e_ov});
  endtask

  // R4 / R6: length rule restated with integers
  function automatic int exp_bytes(output bit ovf);
    int cnt = 255;
    for (int n = 1; n <= 64; n++) begin
      if (n == LIMIT) begin ovf = 1; return n; end
      cnt = (cnt - 1) & 255;
      if (cnt == 0) begin ovf = 0; return n; end
      if (cnt == 251) cnt = (int'(frame[3]) - 3) & 255;
    end
    ovf = 0;
    return 64;
  endfunction

  task automatic set_cks(input int idx, input int delta);
    int s = 0;
    for (int i = 0; i < idx; i++) s += frame[i];
    frame[idx] = 8'((256 - (s & 255)) + delta);
  endtask

  task automatic run_frame(input string tag);
    bit ovf;
    int n, sum, total, bitlen;
    n = exp_bytes(ovf);
    sum = 0;
    for (int i = 0; i < n; i++) sum += frame[i];
    e_done = 1;
    if (ovf) e_ov = 1;
    else begin
      e_new = 1;
      if ((sum & 255) == 0) begin e_ck = 0; e_ov = 0; end
      else e_ck = 1;
    end
    bitlen = n * 8 * (S + G);
    total = bitlen + G;
    @(negedge clk);
    base = falls;
    req = 1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == 0) req = 0;
      if (i < bitlen) chk(sclk == ((i % (S + G)) < S), "R2 clock phase", sclk, (i % (S + G)) < S);
      else chk(sclk == 1, "R7 trailing pulse", sclk, 1);
    end
    @(negedge clk);
    chk(sclk == 0, "R10 clock idle", sclk, 0);
    chk_flags({tag, " flags R5 R6 R7"});
    for (int a = 0; a < n; a++) begin
      rd_addr = 5'(a);
      #1;
      chk(rd_data == frame[a], "R3 buffer byte", rd_data, frame[a]);
    end
  endtask

  task automatic blocked(input string tag);
    @(negedge clk);
    req = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      req = 0;
      chk(sclk == 0, tag, sclk, 0);
    end
    chk_flags({tag, " flags"});
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    e_done = 0; e_new = 0; e_ck = 0; e_ov = 0;
    chk_flags("R8 ack clears");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) frame[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sclk == 0, "R10 reset clock", sclk, 0);
    chk_flags("R8 reset flags");
    chk(guard_busy == 0, "R9 reset guard", guard_busy, 0);

    // R4 good frame, length 6 -> 7 bytes
    frame[0] = 8'h21; frame[1] = 8'h00; frame[2] = 8'hF0; frame[3] = 8'd6;
    frame[4] = 8'hD5; frame[5] = 8'h40; set_cks(6, 0);
    run_frame("R4 good");
    // R9 guard window
    chk(guard_busy == 1, "R9 guard start", guard_busy, 1);
    repeat (GUARD - 1) @(negedge clk);
    chk(guard_busy == 1, "R9 guard last", guard_busy, 1);
    @(negedge clk);
    chk(guard_busy == 0, "R9 guard expiry", guard_busy, 0);

    // R1 ignored while disabled or inhibited
    rx_enable = 0; blocked("R1 disabled"); rx_enable = 1;
    tx_busy = 1;   blocked("R1 inhibited"); tx_busy = 0;
    do_ack();

    // R5 bad checksum
    frame[0] = 8'h21; frame[1] = 8'h00; frame[2] = 8'hF0; frame[3] = 8'd5;
    frame[4] = 8'hD7; set_cks(5, 1);
    run_frame("R5 bad sum");
    do_ack();

    // R4 minimum length byte 4 -> 5 bytes
    frame[0] = 8'h21; frame[1] = 8'h01; frame[2] = 8'hF0; frame[3] = 8'd4;
    set_cks(4, 0);
    run_frame("R4 minimum");
    do_ack();

    // R6 overflow: length 40 would need 41 bytes
    frame[0] = 8'h21; frame[1] = 8'h00; frame[2] = 8'hF0; frame[3] = 8'd40;
    for (int i = 4; i < 64; i++) frame[i] = 8'(i * 7 + 3);
    run_frame("R6 overflow");

    // R5 good frame after overflow, no ack: both errors clear
    frame[0] = 8'h21; frame[1] = 8'h00; frame[2] = 8'hF0; frame[3] = 8'd7;
    frame[4] = 8'hD7; frame[5] = 8'h3C; frame[6] = 8'h81; set_cks(7, 0);
    run_frame("R5 recover");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule